// File: doc/BRIEF.md
# Shared-Source DMA Request Steering

This block sits between the peripheral request lines of a chip and its two DMA channels. One control register selects which of five peripheral request lines feeds channel 1, and a steering flip-flop decides which channel sees the request normally meant for channel 0. The five lines are an external timer-out/request pin, two asynchronous serial ports, a serial communications controller and a parallel port.

Sometimes both channels must serve one device, for example one channel moves a receive buffer while the other refills it. For that case an alternate-enable bit lets the channels' terminal-count pulses flip the steering automatically. The end of a channel-0 transfer hands the device to channel 1, and the end of a channel-1 transfer hands it back.

The request outputs are pure combinational gating of the inputs by the current register state. Only the register itself is clocked.

Top module: `dreq_steer`

## Requirements
- R1: A synchronous active-high reset clears the whole control register, so the readback `rd_data` is 8'h00 in the cycle after reset.
- R2: A write (`wr_en` high) stores `wr_data[7]` as alternate-enable, `wr_data[6]` as the steering flip-flop and `wr_data[2:0]` as the channel-1 source code. Readback bits 5 to 3 are always 0.
- R3: The channel-1 source codes are 000 for `src_req[0]` (external pin), 001 for `src_req[1]` (serial port 0), 010 for `src_req[2]` (serial port 1), 011 for `src_req[3]` (serial controller) and 111 for `src_req[4]` (parallel port). With alternate-enable 0 and steering 0, `ch1_req` follows the selected line.
- R4: Codes 100, 101 and 110 are reserved. With alternate-enable 0 and steering 0, they give `ch1_req` = 0.
- R5: While the steering flip-flop is 1, `ch0_req` is 0 and `ch1_req` equals `ch0_req_in`, whatever the source code.
- R6: While the steering flip-flop is 0, `ch0_req` equals `ch0_req_in`.
- R7: While alternate-enable is 1 and steering is 0, `ch1_req` is 0.
- R8: With alternate-enable 1 and no write, a `tc0_pulse` sets the steering flip-flop at the next clock.
- R9: With alternate-enable 1 and no write, a `tc1_pulse` alone clears the steering flip-flop at the next clock.
- R10: If both terminal-count pulses come in the same cycle with alternate-enable 1, the steering flip-flop ends at 1.
- R11: A write in the same cycle as a terminal-count pulse wins, and the steering flip-flop takes `wr_data[6]`.
- R12: With alternate-enable 0, the terminal-count pulses leave the steering flip-flop unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 5 | Candidate request lines for channel 1 |
| ch0_req_in | input | 1 | Request normally destined for channel 0 |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| tc0_pulse | input | 1 | Channel-0 end-of-transfer pulse |
| tc1_pulse | input | 1 | Channel-1 end-of-transfer pulse |
| rd_data | output | 8 | Control register readback |
| ch0_req | output | 1 | Gated request to channel 0 |
| ch1_req | output | 1 | Gated request to channel 1 |

## Verification
The checker watches, on every cycle, the register-level rules: the reset value, the zero readback bits, write capture, write priority, set and clear by the terminal-count pulses, and no change while alternation is off. It also watches the gating rules that depend only on the readback: exclusive outputs while steering is set or alternation is on, and silence for reserved source codes. Whether each of the five source codes picks the right physical line can only be shown by the bench driving each line on its own. The same holds for a full ping-pong sequence handing one device back and forth.

// File: rtl/dreq_steer_pkg.sv
package dreq_steer_pkg;

    localparam int NUM_SRC = 5;
    localparam int SRC_W   = 3;
    localparam int REG_W   = 8;
    localparam int ALT_BIT = 7;
    localparam int SEL_BIT = 6;
    localparam int SRC_LSB = 0;

    typedef enum logic [SRC_W-1:0] {
        SRC_PIN   = 3'b000,
        SRC_UART0 = 3'b001,
        SRC_UART1 = 3'b010,
        SRC_SCC   = 3'b011,
        SRC_RSV4  = 3'b100,
        SRC_RSV5  = 3'b101,
        SRC_RSV6  = 3'b110,
        SRC_PAR   = 3'b111
    } src_code_e;

    typedef struct packed {
        logic      alt_en;
        logic      sel;
        src_code_e src;
    } ctrl_t;

    typedef struct packed {
        logic set;
        logic clr;
    } tc_evt_t;

    // Code that routes physical request line idx to channel 1.
    function automatic src_code_e code_for_line(int idx);
        case (idx)
            0:       return SRC_PIN;
            1:       return SRC_UART0;
            2:       return SRC_UART1;
            3:       return SRC_SCC;
            default: return SRC_PAR;
        endcase
    endfunction

    function automatic ctrl_t ctrl_from_bus(logic [REG_W-1:0] d);
        ctrl_t c;
        c.alt_en = d[ALT_BIT];
        c.sel    = d[SEL_BIT];
        c.src    = src_code_e'(d[SRC_LSB +: SRC_W]);
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_bus(ctrl_t c);
        logic [REG_W-1:0] d;
        d = '0;
        d[ALT_BIT] = c.alt_en;
        d[SEL_BIT] = c.sel;
        d[SRC_LSB +: SRC_W] = c.src;
        return d;
    endfunction

endpackage

// File: rtl/dreq_steer_ctrl.sv
module dreq_steer_ctrl
    import dreq_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             tc0_pulse,
    input  logic             tc1_pulse,
    output ctrl_t            ctrl_q
);

    tc_evt_t ev;

    always_comb begin
        ev.set = ctrl_q.alt_en & tc0_pulse;
        ev.clr = ctrl_q.alt_en & tc1_pulse;
    end

    // Priority: reset, CPU write, channel-0 set, channel-1 clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= ctrl_from_bus(wr_data);
        end else if (ev.set) begin
            ctrl_q.sel <= 1'b1;
        end else if (ev.clr) begin
            ctrl_q.sel <= 1'b0;
        end
    end

endmodule

// File: rtl/dreq_steer_srcsel.sv
module dreq_steer_srcsel
    import dreq_steer_pkg::*;
#(
    parameter int N_LINES = NUM_SRC
) (
    input  src_code_e          code,
    input  logic [N_LINES-1:0] req,
    output logic               pick
);

    logic [N_LINES-1:0] hit;

    // Reserved codes match no line, so they pick nothing.
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign hit[i] = req[i] & (code == code_for_line(i));
    end

    assign pick = |hit;

endmodule

// File: rtl/dreq_steer_gate.sv
module dreq_steer_gate
    import dreq_steer_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  ch0_req_in,
    input  logic  src_pick,
    output logic  ch0_req,
    output logic  ch1_req
);

    always_comb begin
        ch0_req = ch0_req_in & ~ctrl.sel;
        if (ctrl.sel) begin
            ch1_req = ch0_req_in;
        end else if (ctrl.alt_en) begin
            ch1_req = 1'b0;
        end else begin
            ch1_req = src_pick;
        end
    end

endmodule

// File: rtl/dreq_steer.sv
module dreq_steer
    import dreq_steer_pkg::*;
#(
    parameter int N_LINES = NUM_SRC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] src_req,
    input  logic               ch0_req_in,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               tc0_pulse,
    input  logic               tc1_pulse,
    output logic [REG_W-1:0]   rd_data,
    output logic               ch0_req,
    output logic               ch1_req
);

    ctrl_t ctrl_q;
    logic  src_pick;

    dreq_steer_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tc0_pulse (tc0_pulse),
        .tc1_pulse (tc1_pulse),
        .ctrl_q    (ctrl_q)
    );

    dreq_steer_srcsel #(.N_LINES(N_LINES)) u_src (
        .code (ctrl_q.src),
        .req  (src_req),
        .pick (src_pick)
    );

    dreq_steer_gate u_gate (
        .ctrl       (ctrl_q),
        .ch0_req_in (ch0_req_in),
        .src_pick   (src_pick),
        .ch0_req    (ch0_req),
        .ch1_req    (ch1_req)
    );

    assign rd_data = ctrl_to_bus(ctrl_q);

endmodule

// File: rtl/dreq_steer_chk.sv
module dreq_steer_chk
    import dreq_steer_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic             tc0_pulse,
    input logic             tc1_pulse,
    input logic             ch0_req_in,
    input logic [REG_W-1:0] rd_data,
    input logic             ch0_req,
    input logic             ch1_req
);

    logic alt, sel;
    logic rsv;
    assign alt = rd_data[ALT_BIT];
    assign sel = rd_data[SEL_BIT];
    assign rsv = (rd_data[SRC_LSB +: SRC_W] == SRC_RSV4) ||
                 (rd_data[SRC_LSB +: SRC_W] == SRC_RSV5) ||
                 (rd_data[SRC_LSB +: SRC_W] == SRC_RSV6);

    a_r1_reset_clear: assert property (@(posedge clk) rst |=> (rd_data == '0));

    a_r2_zero_bits: assert property (@(posedge clk) disable iff (rst)
        rd_data[5:3] == 3'b000);

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == ($past(wr_data) & 8'hC7)));

    a_r4_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        (!alt && !sel && rsv) |-> !ch1_req);

    a_r5_steer_one: assert property (@(posedge clk) disable iff (rst)
        sel |-> (!ch0_req && (ch1_req == ch0_req_in)));

    a_r6_pass_ch0: assert property (@(posedge clk) disable iff (rst)
        !sel |-> (ch0_req == ch0_req_in));

    a_r7_alt_exclusive: assert property (@(posedge clk) disable iff (rst)
        (alt && !sel) |-> !ch1_req);

    a_r8_tc0_sets: assert property (@(posedge clk) disable iff (rst)
        (alt && tc0_pulse && !wr_en) |=> rd_data[SEL_BIT]);

    a_r9_tc1_clears: assert property (@(posedge clk) disable iff (rst)
        (alt && tc1_pulse && !tc0_pulse && !wr_en) |=> !rd_data[SEL_BIT]);

    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (tc0_pulse || tc1_pulse)) |=> (rd_data[SEL_BIT] == $past(wr_data[SEL_BIT])));

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!alt && !wr_en) |=> $stable(rd_data));

endmodule

bind dreq_steer dreq_steer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .tc0_pulse  (tc0_pulse),
    .tc1_pulse  (tc1_pulse),
    .ch0_req_in (ch0_req_in),
    .rd_data    (rd_data),
    .ch0_req    (ch0_req),
    .ch1_req    (ch1_req)
);

// File: tb/sim_dreq_steer.sv
`timescale 1ns/1ps
module sim_dreq_steer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] src_req = '0;
    logic       ch0_req_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tc0_pulse = 1'b0;
    logic       tc1_pulse = 1'b0;
    logic [7:0] rd_data;
    logic       ch0_req, ch1_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic       m_alt = 0, m_sel = 0;
    logic [2:0] m_src = 0;
    string      m_tag = "R1";

    always #2 clk = ~clk;

    dreq_steer u0 (
        .clk(clk), .rst(rst), .src_req(src_req), .ch0_req_in(ch0_req_in),
        .wr_en(wr_en), .wr_data(wr_data), .tc0_pulse(tc0_pulse),
        .tc1_pulse(tc1_pulse), .rd_data(rd_data), .ch0_req(ch0_req),
        .ch1_req(ch1_req)
    );

    function automatic logic pick_line(logic [2:0] code, logic [4:0] r);
        case (code)
            3'b000: return r[0];
            3'b001: return r[1];
            3'b010: return r[2];
            3'b011: return r[3];
            3'b111: return r[4];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_ch1(logic alt, logic sel, logic [2:0] code,
                                     logic [4:0] r, logic c0);
        if (sel) return c0;
        if (alt) return 1'b0;
        return pick_line(code, r);
    endfunction

    function automatic string ch1_tag(logic alt, logic sel, logic [2:0] code);
        if (sel) return "R5";
        if (alt) return "R7";
        if (code inside {3'b100, 3'b101, 3'b110}) return "R4";
        return "R3";
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check outputs, then update model.
    task automatic cycle(logic w, logic [7:0] wd, logic t0, logic t1,
                         logic [4:0] r, logic c0);
        @(negedge clk);
        check(m_tag, rd_data, {m_alt, m_sel, 3'b000, m_src});
        wr_en = w; wr_data = wd; tc0_pulse = t0; tc1_pulse = t1;
        src_req = r; ch0_req_in = c0;
        #1;
        check(m_sel ? "R5" : "R6", {7'b0, ch0_req}, {7'b0, c0 & ~m_sel});
        check(ch1_tag(m_alt, m_sel, m_src), {7'b0, ch1_req},
              {7'b0, exp_ch1(m_alt, m_sel, m_src, r, c0)});
        @(posedge clk);
        if (w) begin
            m_tag = (m_alt && (t0 || t1)) ? "R11" : "R2";
            m_alt = wd[7]; m_sel = wd[6]; m_src = wd[2:0];
        end else if (m_alt && t0) begin
            m_tag = t1 ? "R10" : "R8";
            m_sel = 1'b1;
        end else if (m_alt && t1) begin
            m_tag = "R9";
            m_sel = 1'b0;
        end else begin
            m_tag = (t0 || t1) ? "R12" : "R2";
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_tag = "R1";
        // R1: reset state, ch0 passes through.
        cycle(0, 8'h00, 0, 0, 5'h00, 1);

        // R3 / R4: every code, each line alone.
        for (int code = 0; code < 8; code++) begin
            cycle(1, 8'(code), 0, 0, 5'h00, 0);
            for (int ln = 0; ln < 5; ln++) cycle(0, 8'h00, 0, 0, 5'(1 << ln), 0);
            cycle(0, 8'h00, 0, 0, 5'h1F, 1);
        end
        // R2: unused bits read 0.
        cycle(1, 8'h3A, 0, 0, 5'h00, 0);
        cycle(0, 8'h00, 0, 0, 5'h04, 0);

        // R8 / R9: ping-pong with alternation on.
        cycle(1, 8'h81, 0, 0, 5'h02, 1);
        cycle(0, 8'h00, 1, 0, 5'h02, 1);
        cycle(0, 8'h00, 0, 0, 5'h02, 1);
        cycle(0, 8'h00, 0, 1, 5'h02, 1);
        cycle(0, 8'h00, 0, 0, 5'h02, 1);
        // R10: both pulses together.
        cycle(0, 8'h00, 1, 1, 5'h00, 1);
        cycle(0, 8'h00, 0, 0, 5'h00, 1);
        // R11: write beats pulses.
        cycle(1, 8'h80, 1, 0, 5'h00, 1);
        cycle(0, 8'h00, 0, 0, 5'h00, 1);
        cycle(1, 8'hC0, 0, 1, 5'h00, 1);
        cycle(0, 8'h00, 0, 0, 5'h00, 1);
        // R12: alternation off, pulses ignored.
        cycle(1, 8'h47, 0, 0, 5'h10, 1);
        cycle(0, 8'h00, 0, 1, 5'h10, 1);
        cycle(1, 8'h07, 0, 0, 5'h10, 1);
        cycle(0, 8'h00, 1, 0, 5'h10, 1);
        cycle(0, 8'h00, 0, 0, 5'h10, 0);

        // Random mix.
        for (int k = 0; k < 4000; k++) begin
            logic w;
            w = ($urandom % 8) == 0;
            cycle(w, 8'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
                  5'($urandom), 1'($urandom));
        end
        cycle(0, 8'h00, 0, 0, 5'h00, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule